// File: doc/BRIEF.md
# NAND Flash Host Interface Controller

This block sits between a simple register bus and an 8-bit NAND flash device. Software programs a configuration word that turns the controller on, selects or releases the chip, and sets three phase lengths: setup, strobe-active and hold. Each write to the command register becomes one latch cycle with the command-latch line high. Each write to the address register becomes one latch cycle with the address-latch line high. Each data-register access becomes one write or read strobe. The register bus is stalled through `bus_wait` until the flash cycle has finished, so two flash cycles never overlap.

A status register shows the synchronised ready/busy pin of the flash. An error-code accumulator builds a 24-bit line/column parity code over the data bytes moved since it was last cleared. It covers one run of 512 bytes and ignores any further bytes. A configuration write with the clear bit set restarts the run.

Top module: `nand_host_ctrl`

## Requirements
- R1: After reset `nf_ce_n`=1, `nf_we_n`=1, `nf_re_n`=1, `nf_cle`=0, `nf_ale`=0, `nf_io_oe`=0, `bus_wait`=0, and the configuration word (offset 0x00) reads 0x0000.
- R2: The configuration word keeps bit 15 (enable), bit 11 (chip release), bits [10:8] (setup), bits [6:4] (active) and bits [2:0] (hold). All other bits, including the clear bit 12, read back as 0, so writing 0xFFFF reads back 0x8F77.
- R3: `nf_ce_n` is 0 only while the enable bit is 1 and bit 11 is 0. Otherwise it is 1.
- R4: A write to offset 0x04 while enabled produces exactly one `nf_we_n` low pulse. `nf_cle` is high and `nf_ale` is low for the whole cycle, and `nf_io_out` carries `bus_wdata[7:0]` with `nf_io_oe` high throughout.
- R5: A write to offset 0x08 while enabled produces one `nf_we_n` pulse with `nf_ale` high and `nf_cle` low throughout, driving the written byte.
- R6: A flash cycle holds its strobe high for (bits[10:8]+1) cycles, low for (bits[6:4]+1) cycles, then high for (bits[2:0]+1) cycles. `bus_wait` is high for exactly their sum, starting the cycle after the request is taken.
- R7: A write to offset 0x0C pulses `nf_we_n` with the written byte driven. A read of 0x0C pulses `nf_re_n` with `nf_io_oe` low and both latch lines low. In both cases `bus_rdata` ends up as `nf_io_in` sampled in the last strobe-low cycle, zero-extended, by the time `bus_wait` falls.
- R8: A request made while `bus_wait` is high is ignored. It starts no second strobe and does not disturb the cycle in progress.
- R9: While the enable bit is 0, accesses to 0x04, 0x08 and 0x0C start no strobe and never raise `bus_wait`.
- R10: Reading offset 0x10 returns `nf_rdy` in bit 0 (1 = ready) and zeros above. A change on `nf_rdy` is visible within three clock cycles.
- R11: Offsets 0x14, 0x15 and 0x16 return the three code bytes in `bus_rdata[7:0]`. Take the byte index i (9 bits) since the last clear and the byte parity p. Line bit pairs are odd[b], the XOR of p over bytes with i[b]=1, and even[b], the XOR of p over bytes with i[b]=0. They are packed as code bit 2b = even[b] and code bit 2b+1 = odd[b] for b=0..8. Column pairs for k=0..2 XOR the data bits whose bit position has bit k equal to 0 (even) or 1 (odd), and sit at code bits 18+2k and 19+2k. Byte 0x14 holds code bits [7:0], 0x15 holds [15:8] and 0x16 holds [23:16].
- R12: A configuration write with bit 12 set zeroes the code and restarts the run. Bytes after the 512th since the clear leave the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request, taken when `bus_wait` is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the last read access |
| bus_wait | output | 1 | High while a flash cycle runs; requests are ignored |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven onto the flash I/O bus |
| nf_io_oe | output | 1 | Output enable of the flash I/O bus |
| nf_io_in | input | 8 | Byte read from the flash I/O bus |
| nf_rdy | input | 1 | Flash ready/busy pin, 1 = ready |

## Verification
A phase counter stuck or loaded with the wrong field shows up during the first flash cycle as a strobe pulse of the wrong length or a `bus_wait` window of the wrong length. Both are visible at the pins within a few cycles of the request. A wrong cycle type shows as the wrong latch line during that same cycle. A sampling slip in a read shows in `bus_rdata` as soon as `bus_wait` drops. A fault in the error-code accumulator stays hidden until the code bytes are read, so the bench reads them after short runs, after a full 512-byte run with extra bytes, and after a clear.

// File: rtl/nfc_pkg.sv
// Shared constants and types for the NAND host controller.
// Assumes byte offsets on a 5-bit register address.
package nfc_pkg;

    localparam int TW = 3;  // width of each timing field

    localparam int OFF_CFG  = 'h00;
    localparam int OFF_CMD  = 'h04;
    localparam int OFF_ADR  = 'h08;
    localparam int OFF_DAT  = 'h0C;
    localparam int OFF_STAT = 'h10;
    localparam int OFF_ECC0 = 'h14;
    localparam int OFF_ECC1 = 'h15;
    localparam int OFF_ECC2 = 'h16;

    typedef enum logic [1:0] {
        CYC_CMD = 2'd0,
        CYC_ADR = 2'd1,
        CYC_DAT = 2'd2
    } cyc_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef struct packed {
        logic          en;
        logic          ce_off;
        logic [TW-1:0] t_setup;
        logic [TW-1:0] t_active;
        logic [TW-1:0] t_hold;
    } cfg_t;

endpackage

// File: rtl/nfc_cfg_reg.sv
// Configuration word holder.
// Keeps enable, chip release and the three timing fields. Bit 12 is a
// write-one strobe that clears the error-code accumulator and is not stored.
// Assumes writes arrive only while no flash cycle runs.
module nfc_cfg_reg
    import nfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output cfg_t        cfg,
    output logic        ecc_clr,
    output logic [15:0] rd_word
);

    logic unused_bits;
    assign unused_bits = ^{wdata[14:13], wdata[7], wdata[3]};

    // Store the kept fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.en       <= wdata[15];
            cfg.ce_off   <= wdata[11];
            cfg.t_setup  <= wdata[8 +: TW];
            cfg.t_active <= wdata[4 +: TW];
            cfg.t_hold   <= wdata[0 +: TW];
        end
    end

    // Clear pulse for the accumulator.
    assign ecc_clr = wr_en & wdata[12];

    // Read-back image of the stored word.
    always_comb begin
        rd_word           = '0;
        rd_word[15]       = cfg.en;
        rd_word[11]       = cfg.ce_off;
        rd_word[8 +: TW]  = cfg.t_setup;
        rd_word[4 +: TW]  = cfg.t_active;
        rd_word[0 +: TW]  = cfg.t_hold;
    end

endmodule

// File: rtl/nfc_strobe_seq.sv
// Flash cycle sequencer.
// One start runs setup, active and hold phases. Each phase lasts its field
// plus one cycles. The latch lines and driven byte stay valid for the whole
// cycle, and the strobe is low only in the active phase. Assumes the timing
// inputs stay stable while busy.
module nfc_strobe_seq
    import nfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  cyc_kind_t     kind,
    input  logic          is_read,
    input  logic [DW-1:0] wbyte,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_active,
    input  logic [TW-1:0] t_hold,
    output logic          busy,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] io_out,
    output logic          io_oe,
    output logic          rd_sample
);

    phase_t        ph;
    logic [TW-1:0] cnt;
    cyc_kind_t     kind_q;
    logic          rd_q;
    logic [DW-1:0] wb_q;
    logic          last;

    assign last = (cnt == '0);

    // Phase state and down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            kind_q <= CYC_CMD;
            rd_q   <= 1'b0;
            wb_q   <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph     <= PH_SETUP;
                    cnt    <= t_setup;
                    kind_q <= kind;
                    rd_q   <= is_read;
                    wb_q   <= wbyte;
                end
                PH_SETUP: if (last) begin
                    ph  <= PH_ACTIVE;
                    cnt <= t_active;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_ACTIVE: if (last) begin
                    ph  <= PH_HOLD;
                    cnt <= t_hold;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (last) begin
                    ph <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Pin decode from the registered phase.
    always_comb begin
        busy      = (ph != PH_IDLE);
        cle       = busy && (kind_q == CYC_CMD);
        ale       = busy && (kind_q == CYC_ADR);
        we_n      = !((ph == PH_ACTIVE) && !rd_q);
        re_n      = !((ph == PH_ACTIVE) && rd_q);
        io_oe     = busy && !rd_q;
        io_out    = io_oe ? wb_q : '0;
        rd_sample = (ph == PH_ACTIVE) && last && rd_q;
    end

endmodule

// File: rtl/nfc_ecc_acc.sv
// Line/column parity accumulator over one run of data bytes.
// Line pairs follow the byte index bits and column pairs follow the bit
// position bits. Assumes RUN_BYTES and DW are powers of two. Bytes beyond
// the run are ignored until the next clear.
module nfc_ecc_acc #(
    parameter int DW        = 8,
    parameter int RUN_BYTES = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_in,
    output logic [2*($clog2(RUN_BYTES)+$clog2(DW))-1:0] ecc
);

    localparam int IW = $clog2(RUN_BYTES);
    localparam int CW = $clog2(DW);

    logic [IW:0]   idx;
    logic [IW-1:0] lp_e, lp_o;
    logic [CW-1:0] cp_e, cp_o;
    logic          par;
    logic [CW-1:0] col_e, col_o;

    // Byte parity and per-position column parities of the incoming byte.
    always_comb begin
        par   = ^byte_in;
        col_e = '0;
        col_o = '0;
        for (int k = 0; k < CW; k++) begin
            for (int j = 0; j < DW; j++) begin
                if (((j >> k) & 1) != 0) col_o[k] = col_o[k] ^ byte_in[j];
                else                     col_e[k] = col_e[k] ^ byte_in[j];
            end
        end
    end

    // Fold each in-run byte into the code.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx  <= '0;
            lp_e <= '0;
            lp_o <= '0;
            cp_e <= '0;
            cp_o <= '0;
        end else if (byte_vld && !idx[IW]) begin
            idx  <= idx + 1'b1;
            lp_o <= lp_o ^ ({IW{par}} & idx[IW-1:0]);
            lp_e <= lp_e ^ ({IW{par}} & ~idx[IW-1:0]);
            cp_e <= cp_e ^ col_e;
            cp_o <= cp_o ^ col_o;
        end
    end

    // Interleave even/odd pairs into the code word.
    for (genvar g = 0; g < IW; g++) begin : g_line
        assign ecc[2*g]     = lp_e[g];
        assign ecc[2*g + 1] = lp_o[g];
    end
    for (genvar c = 0; c < CW; c++) begin : g_col
        assign ecc[2*IW + 2*c]     = cp_e[c];
        assign ecc[2*IW + 2*c + 1] = cp_o[c];
    end

endmodule

// File: rtl/nand_host_ctrl.sv
// NAND flash host interface controller, top level.
// Decodes register accesses, starts flash cycles through the sequencer,
// stalls the bus with bus_wait while a cycle runs, synchronises the ready
// pin and feeds moved data bytes to the error-code accumulator.
// Assumes requests are ignored while bus_wait is high.
module nand_host_ctrl
    import nfc_pkg::*;
#(
    parameter int AW          = 5,
    parameter int DW          = 8,
    parameter int RUN_BYTES   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          bus_wait,
    output logic          nf_ce_n,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic          nf_we_n,
    output logic          nf_re_n,
    output logic [DW-1:0] nf_io_out,
    output logic          nf_io_oe,
    input  logic [DW-1:0] nf_io_in,
    input  logic          nf_rdy
);

    localparam int ECC_W = 2 * ($clog2(RUN_BYTES) + $clog2(DW));
    localparam logic [AW-1:0] A_CFG  = AW'(OFF_CFG);
    localparam logic [AW-1:0] A_CMD  = AW'(OFF_CMD);
    localparam logic [AW-1:0] A_ADR  = AW'(OFF_ADR);
    localparam logic [AW-1:0] A_DAT  = AW'(OFF_DAT);
    localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
    localparam logic [AW-1:0] A_ECC0 = AW'(OFF_ECC0);
    localparam logic [AW-1:0] A_ECC1 = AW'(OFF_ECC1);
    localparam logic [AW-1:0] A_ECC2 = AW'(OFF_ECC2);

    cfg_t             cfg;
    logic             cfg_en;
    logic             ecc_clr;
    logic [15:0]      cfg_word;
    logic             busy;
    logic             accept;
    logic             cfg_wr;
    logic             flash_hit;
    logic             start;
    cyc_kind_t        kind;
    logic             rd_sample;
    logic             ecc_vld;
    logic [DW-1:0]    ecc_byte;
    logic [ECC_W-1:0] ecc;
    logic             rdy_s;
    logic [15:0]      reg_mux;

    assign accept = bus_req && !busy;
    assign cfg_wr = accept && bus_we && (bus_addr == A_CFG);
    assign cfg_en = cfg.en;

    // Pick the flash cycle type from the offset.
    always_comb begin
        flash_hit = 1'b0;
        kind      = CYC_DAT;
        if (bus_addr == A_CMD && bus_we) begin
            flash_hit = 1'b1;
            kind      = CYC_CMD;
        end else if (bus_addr == A_ADR && bus_we) begin
            flash_hit = 1'b1;
            kind      = CYC_ADR;
        end else if (bus_addr == A_DAT) begin
            flash_hit = 1'b1;
        end
    end

    assign start = accept && cfg.en && flash_hit;

    nfc_cfg_reg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wdata   (bus_wdata),
        .cfg     (cfg),
        .ecc_clr (ecc_clr),
        .rd_word (cfg_word)
    );

    nfc_strobe_seq #(.DW(DW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind      (kind),
        .is_read   (!bus_we),
        .wbyte     (bus_wdata[DW-1:0]),
        .t_setup   (cfg.t_setup),
        .t_active  (cfg.t_active),
        .t_hold    (cfg.t_hold),
        .busy      (busy),
        .cle       (nf_cle),
        .ale       (nf_ale),
        .we_n      (nf_we_n),
        .re_n      (nf_re_n),
        .io_out    (nf_io_out),
        .io_oe     (nf_io_oe),
        .rd_sample (rd_sample)
    );

    // Data bytes entering the code: written bytes at start, read bytes at sample.
    assign ecc_vld  = (start && bus_we && kind == CYC_DAT) || rd_sample;
    assign ecc_byte = rd_sample ? nf_io_in : bus_wdata[DW-1:0];

    nfc_ecc_acc #(.DW(DW), .RUN_BYTES(RUN_BYTES)) i_ecc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ecc_clr),
        .byte_vld (ecc_vld),
        .byte_in  (ecc_byte),
        .ecc      (ecc)
    );

    // Ready pin synchroniser, depth chosen by parameter.
    if (SYNC_STAGES == 0) begin : g_nosync
        assign rdy_s = nf_rdy;
    end else begin : g_sync
        logic [SYNC_STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= SYNC_STAGES'({sh, nf_rdy});
        end
        assign rdy_s = sh[SYNC_STAGES-1];
    end

    // Read multiplexer for the plain registers.
    always_comb begin
        reg_mux = '0;
        case (bus_addr)
            A_CFG:   reg_mux = cfg_word;
            A_STAT:  reg_mux = {15'd0, rdy_s};
            A_ECC0:  reg_mux = {8'd0, ecc[7:0]};
            A_ECC1:  reg_mux = {8'd0, ecc[15:8]};
            A_ECC2:  reg_mux = {8'd0, ecc[23:16]};
            default: reg_mux = '0;
        endcase
    end

    // Read data register: plain reads at accept, flash reads at sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_sample) begin
            bus_rdata <= 16'(nf_io_in);
        end else if (accept && !bus_we && !start) begin
            bus_rdata <= reg_mux;
        end
    end

    assign bus_wait = busy;
    assign nf_ce_n  = !cfg.en || cfg.ce_off;

endmodule

// File: rtl/nfc_checker.sv
// Protocol checker for the NAND host controller, bound to the top.
// Assumes synchronous active-low reset.
module nfc_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_en,
    input logic          bus_wait,
    input logic          nf_cle,
    input logic          nf_ale,
    input logic          nf_we_n,
    input logic          nf_re_n,
    input logic          nf_io_oe,
    input logic [DW-1:0] nf_io_out
);

    // R4/R5: the two latch lines never rise together.
    a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    // R8: only one strobe at a time.
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    // R6: a strobe only inside a bus_wait window.
    a_r6_strobe_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> bus_wait);

    // R6: the first cycle of a window is setup, with the strobes high.
    a_r6_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wait) |-> (nf_we_n && nf_re_n));

    // R7: the bus is not driven during a read strobe.
    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_io_oe);

    // R8: the driven byte holds for a whole cycle.
    a_r8_io_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wait && $past(bus_wait) && nf_io_oe) |-> $stable(nf_io_out));

    // R9: a disabled controller stays idle.
    a_r9_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !bus_wait) |=> !bus_wait);

endmodule

bind nand_host_ctrl nfc_checker #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .bus_wait  (bus_wait),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_io_oe  (nf_io_oe),
    .nf_io_out (nf_io_out)
);

// File: tb/test_nand_host_ctrl.sv
`timescale 1ns/1ps
module test_nand_host_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_wait;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out;
    logic [7:0]  nf_io_in = '0;
    logic        nf_rdy = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] pat [0:519];

    always #2.5 clk = ~clk;

    nand_host_ctrl i_nand_host_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rdy(nf_rdy)
    );

    // Vector: {offset[7:0], read, setup[2:0], active[2:0], hold[2:0], byte[7:0]}
    localparam logic [25:0] VEC [6] = '{
        {8'h04, 1'b0, 3'd0, 3'd0, 3'd0, 8'hFF},
        {8'h08, 1'b0, 3'd2, 3'd5, 3'd1, 8'h3A},
        {8'h0C, 1'b0, 3'd7, 3'd7, 3'd7, 8'hC5},
        {8'h0C, 1'b1, 3'd1, 3'd3, 3'd0, 8'h96},
        {8'h04, 1'b0, 3'd3, 3'd0, 3'd2, 8'h70},
        {8'h0C, 1'b1, 3'd0, 3'd0, 3'd0, 8'h5A}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    // Run one flash cycle and measure it at the pins.
    task automatic flash_op(input logic [4:0] a, input bit rd, input logic [7:0] d,
                            input bit exp_cle, input bit exp_ale,
                            output int s, output int act, output int h,
                            output int bad_lat, output int bad_io);
        s = 0; act = 0; h = 0; bad_lat = 0; bad_io = 0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = !rd; bus_addr = a; bus_wdata = {8'h00, d};
        while (1) begin
            @(negedge clk);
            bus_req = 1'b0;
            if (!bus_wait) break;
            if (nf_cle != exp_cle || nf_ale != exp_ale) bad_lat++;
            if (rd ? (nf_io_oe || !nf_we_n) : (!nf_io_oe || nf_io_out != d || !nf_re_n)) bad_io++;
            if (rd ? !nf_re_n : !nf_we_n) act++;
            else if (act == 0) s++;
            else h++;
        end
    endtask

    function automatic logic [23:0] ref_ecc(input int n);
        logic [8:0] le = '0, lo = '0;
        logic [2:0] ce = '0, co = '0;
        for (int i = 0; i < n && i < 512; i++) begin
            logic p = ^pat[i];
            for (int b = 0; b < 9; b++)
                if (((i >> b) & 1) != 0) lo[b] ^= p; else le[b] ^= p;
            for (int j = 0; j < 8; j++)
                for (int k = 0; k < 3; k++)
                    if (((j >> k) & 1) != 0) co[k] ^= pat[i][j]; else ce[k] ^= pat[i][j];
        end
        return {co[2], ce[2], co[1], ce[1], co[0], ce[0], lo[8], le[8],
                lo[7], le[7], lo[6], le[6], lo[5], le[5], lo[4], le[4],
                lo[3], le[3], lo[2], le[2], lo[1], le[1], lo[0], le[0]};
    endfunction

    task automatic read_ecc(output logic [23:0] e);
        logic [15:0] b0, b1, b2;
        reg_rd(5'h14, b0); reg_rd(5'h15, b1); reg_rd(5'h16, b2);
        e = {b2[7:0], b1[7:0], b0[7:0]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        logic [23:0] ev;
        int s, act, h, bl, bi;
        for (int i = 0; i < 520; i++) pat[i] = 8'((i * 37 + 11) ^ (i >> 3));

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_io_oe && !bus_wait,
              "R1 pins", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, bus_wait}, 7'b1110000);
        reg_rd(5'h00, rv);
        check(rv == 16'h0000, "R1 cfg", rv, 0);

        // R2: kept bits
        reg_wr(5'h00, 16'hFFFF);
        reg_rd(5'h00, rv);
        check(rv == 16'h8F77, "R2 readback", rv, 16'h8F77);
        // R3: chip enable
        check(nf_ce_n == 1'b1, "R3 released", nf_ce_n, 1);
        reg_wr(5'h00, 16'h8000);
        @(negedge clk);
        check(nf_ce_n == 1'b0, "R3 selected", nf_ce_n, 0);
        reg_wr(5'h00, 16'h0000);
        @(negedge clk);
        check(nf_ce_n == 1'b1, "R3 disabled", nf_ce_n, 1);

        // R9: disabled controller ignores flash accesses
        flash_op(5'h04, 1'b0, 8'h90, 1'b1, 1'b0, s, act, h, bl, bi);
        check(s + act + h == 0 && nf_we_n && !bus_wait, "R9 no cycle", s + act + h, 0);

        // R4 R5 R6 R7: vector table
        foreach (VEC[v]) begin
            logic [7:0] off = VEC[v][25:18];
            bit         rd  = VEC[v][17];
            int         ts  = int'(VEC[v][16:14]);
            int         ta  = int'(VEC[v][13:11]);
            int         th  = int'(VEC[v][10:8]);
            logic [7:0] d   = VEC[v][7:0];
            reg_wr(5'h00, 16'h8000 | 16'(ts << 8) | 16'(ta << 4) | 16'(th));
            nf_io_in = d;
            flash_op(off[4:0], rd, d, off == 8'h04, off == 8'h08, s, act, h, bl, bi);
            check(s == ts + 1, "R6 setup", s, ts + 1);
            check(act == ta + 1, "R6 active", act, ta + 1);
            check(h == th + 1, "R6 hold", h, th + 1);
            check(bl == 0, "R4/R5 latch lines (R4 R5)", bl, 0);
            check(bi == 0, "R7 io drive", bi, 0);
            if (rd) check(bus_rdata == {8'h00, d}, "R7 read data", bus_rdata, d);
        end

        // R8: request during busy ignored
        reg_wr(5'h00, 16'h8777);
        begin
            int alec = 0, falls = 0, bad = 0;
            logic pw = 1'b1;
            @(negedge clk);
            bus_req = 1'b1; bus_we = 1'b1; bus_addr = 5'h04; bus_wdata = 16'h00AA;
            @(negedge clk);
            bus_addr = 5'h08; bus_wdata = 16'h0055;
            while (bus_wait) begin
                if (nf_ale) alec++;
                if (pw && !nf_we_n) falls++;
                if (nf_io_oe && nf_io_out != 8'hAA) bad++;
                pw = nf_we_n;
                @(negedge clk);
            end
            bus_req = 1'b0;
            check(alec == 0 && bad == 0, "R8 no disturbance", alec + bad, 0);
            check(falls == 1, "R8 single strobe", falls, 1);
        end

        // R10: ready status
        nf_rdy = 1'b0;
        repeat (3) @(negedge clk);
        reg_rd(5'h10, rv);
        check(rv == 16'h0000, "R10 busy", rv, 0);
        nf_rdy = 1'b1;
        repeat (3) @(negedge clk);
        reg_rd(5'h10, rv);
        check(rv == 16'h0001, "R10 ready", rv, 1);

        // R11: short run of written bytes
        reg_wr(5'h00, 16'h9000);
        for (int i = 0; i < 5; i++) flash_op(5'h0C, 1'b0, pat[i], 1'b0, 1'b0, s, act, h, bl, bi);
        read_ecc(ev);
        check(ev == ref_ecc(5), "R11 short run", ev, ref_ecc(5));

        // R11: read bytes join the code
        reg_wr(5'h00, 16'h9000);
        for (int i = 0; i < 3; i++) begin
            nf_io_in = pat[i];
            flash_op(5'h0C, 1'b1, pat[i], 1'b0, 1'b0, s, act, h, bl, bi);
        end
        read_ecc(ev);
        check(ev == ref_ecc(3), "R11 read run", ev, ref_ecc(3));

        // R12: full run plus extra bytes, then clear
        reg_wr(5'h00, 16'h9000);
        for (int i = 0; i < 515; i++) flash_op(5'h0C, 1'b0, pat[i], 1'b0, 1'b0, s, act, h, bl, bi);
        read_ecc(ev);
        check(ev == ref_ecc(512), "R12 run limit", ev, ref_ecc(512));
        reg_wr(5'h00, 16'h9000);
        read_ecc(ev);
        check(ev == 24'h0, "R12 clear", ev, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule